// File: doc/BRIEF.md
# Prioritized Interrupt Controller Register Bank

This block collects up to 240 interrupt lines and keeps three state bits for each one: enabled, pending and active. It also holds a small priority value for each line. Software reaches all of this through a word-wide register port with byte enables. Enable and pending state change only through separate set and clear aliases, where each written 1 acts on one line. A write-only trigger register lets software pend a line by its number. The active bits can be read but not written.

Every cycle an arbiter looks for the enabled, pending line with the most urgent priority. A lower priority value is more urgent. The arbiter presents that line to the processor side, together with a flag that says whether the line may interrupt the work already in progress. A grouping value splits each priority into a preemption part (the upper bits) and a sub-priority part (the lower bits). Only the preemption part decides nesting.

The processor side acknowledges a presented request to make it active. When the handler finishes, the processor side names the line in an end-of-service strobe. Hardware lines pend on a rising edge, whatever their enable state.

Top module: `irqc_top`

## Requirements
- R1: Enable state. Writing 1s to the set alias at 0x000+4w enables lines and writing 1s to the clear alias at 0x080+4w disables them. Line n sits in word w=n>>5, bit n&31. Zero bits have no effect, and only lanes with `bus_be` high take part. Reading either alias returns the enable state. Bits of lines that do not exist read as 0.
- R2: Pending state. Writing 1s to the set alias at 0x100+4w pends lines and writing 1s to the clear alias at 0x180+4w un-pends them. The same bit layout and the same zero/readback rules as R1 apply.
- R3: Active status is read at 0x200+4w with the R1 bit layout. Writes to that range have no effect.
- R4: The priority of line n is held in byte n&3 of the word at 0x300+4*(n>>2). Only the upper PRIO_BITS bits of that byte are stored, and the lower bits read as 0. A byte lane is written only when its `bus_be` bit is set.
- R5: Writing a line number into bits [8:0] at 0xE00 pends that line. A number at or above NUM_LINES is ignored. Reads at 0xE00 return 0.
- R6: A rising edge on `irq_in[n]` pends line n, even when the line is disabled. A level that stays high does not pend the line again after it is cleared.
- R7: `irq_valid`, `irq_line` and `irq_prio` show the enabled, pending line with the lowest priority value, with ties going to the lowest line number. They are registered, one cycle after the state. A disabled line is never shown.
- R8: With grouping value g on `prio_group`, the top g priority bits form the preemption field. A value of g above PRIO_BITS acts as PRIO_BITS.
- R9: `irq_take` is high when a request is shown and either no line is active, or the request's preemption field is strictly below the smallest preemption field among the active lines.
- R10: `irq_ack` while `irq_take` is high clears the shown line's pending bit and sets its active bit. `irq_valid` and `irq_take` read 0 in the following cycle.
- R11: `eos_valid` clears the active bit of line `eos_line`.
- R12: Reset clears all enable, pending, active and priority state, `bus_rdata` and the request outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` one cycle later |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| prio_group | input | GW | Grouping value that splits priority into preemption and sub-priority |
| irq_in | input | NUM_LINES | Hardware interrupt lines, edge sensitive |
| irq_valid | output | 1 | A selected request is shown |
| irq_take | output | 1 | The shown request may preempt the current work |
| irq_line | output | LW | Line number of the shown request |
| irq_prio | output | PRIO_BITS | Priority of the shown request |
| irq_ack | input | 1 | Accept the shown request (effective only while `irq_take` is high) |
| eos_valid | input | 1 | End-of-service strobe |
| eos_line | input | LW | Line whose service ends |

## Verification
The bench builds the block with NUM_LINES=40 and PRIO_BITS=4. With 40 lines the second bank word is only partly filled and the third word does not exist, so the zero readback of missing lines can be observed, and a trigger number of 45 falls outside the line range. Four priority bits let one bench walk every grouping value from 0 to 4, plus one value above the limit. It uses priorities that tie in the preemption field but differ in sub-priority, so it can show that nesting is refused while the waiting order still follows the full value.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam logic [11:0] ADR_TRIG = 12'hE00;
  localparam int unsigned TRIG_W   = 9;

  typedef enum logic [2:0] {
    BK_EN_SET, BK_EN_CLR, BK_PD_SET, BK_PD_CLR, BK_ACT, BK_PRIO, BK_TRIG, BK_NONE
  } bank_e;

  // Address decode: set/clear/active banks occupy 0x000..0x27F in
  // 128-byte strides, eight words each; priority bytes at 0x300..0x3FF.
  function automatic bank_e bank_of(input logic [11:0] a);
    bank_e b;
    b = BK_NONE;
    if (a == ADR_TRIG)            b = BK_TRIG;
    else if (a[11:8] == 4'h3)     b = BK_PRIO;
    else if (a[6:5] == 2'b00) begin
      case (a[11:7])
        5'd0:    b = BK_EN_SET;
        5'd1:    b = BK_EN_CLR;
        5'd2:    b = BK_PD_SET;
        5'd3:    b = BK_PD_CLR;
        5'd4:    b = BK_ACT;
        default: b = BK_NONE;
      endcase
    end
    return b;
  endfunction

endpackage

// File: rtl/irqc_line_state.sv
module irqc_line_state #(
  parameter int N = 240
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] en_set,
  input  logic [N-1:0] en_clr,
  input  logic [N-1:0] pd_set,
  input  logic [N-1:0] pd_clr,
  input  logic [N-1:0] act_set,
  input  logic [N-1:0] act_clr,
  output logic [N-1:0] en_q,
  output logic [N-1:0] pd_q,
  output logic [N-1:0] act_q
);

  logic [N-1:0] irq_prev;
  logic [N-1:0] irq_edge;

  assign irq_edge = irq_in & ~irq_prev;

  // Set sources win over clear sources, so a fresh edge arriving with an
  // acknowledge of the same line leaves the line pending.
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_prev <= '0;
      en_q     <= '0;
      pd_q     <= '0;
      act_q    <= '0;
    end else begin
      irq_prev <= irq_in;
      en_q     <= (en_q  & ~en_clr)  | en_set;
      pd_q     <= (pd_q  & ~pd_clr)  | pd_set | irq_edge;
      act_q    <= (act_q & ~act_clr) | act_set;
    end
  end

endmodule

// File: rtl/irqc_prio_store.sv
module irqc_prio_store #(
  parameter int N  = 240,
  parameter int PB = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         wr_mask,
  input  logic [31:0]          wdata,
  output logic [N-1:0][PB-1:0] prio_q
);

  // Each line takes the upper PB bits of its own byte lane.
  for (genvar i = 0; i < N; i++) begin : g_line
    localparam int TOP = 8 * (i % 4) + 7;
    always_ff @(posedge clk) begin
      if (rst)             prio_q[i] <= '0;
      else if (wr_mask[i]) prio_q[i] <= wdata[TOP -: PB];
    end
  end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int N  = 240,
  parameter int PB = 4,
  parameter int GW = 3,
  parameter int LW = 8
) (
  input  logic [N-1:0]         en,
  input  logic [N-1:0]         pd,
  input  logic [N-1:0]         act,
  input  logic [N-1:0][PB-1:0] prio,
  input  logic [GW-1:0]        group,
  output logic                 cand_valid,
  output logic [LW-1:0]        cand_line,
  output logic [PB-1:0]        cand_prio,
  output logic                 cand_take
);

  logic [GW-1:0] g_eff;
  logic [PB-1:0] pmask;
  logic          run_v;
  logic [PB-1:0] run_p;

  assign g_eff = (group > GW'(PB)) ? GW'(PB) : group;
  assign pmask = ~({PB{1'b1}} >> g_eff);

  // Strict compare keeps the lowest line number on equal priority.
  always_comb begin
    cand_valid = 1'b0;
    cand_line  = '0;
    cand_prio  = '1;
    for (int i = 0; i < N; i++) begin
      if (en[i] && pd[i] && (!cand_valid || prio[i] < cand_prio)) begin
        cand_valid = 1'b1;
        cand_prio  = prio[i];
        cand_line  = LW'(i);
      end
    end
  end

  // Running level: most urgent preemption field among active lines.
  always_comb begin
    run_v = 1'b0;
    run_p = '1;
    for (int i = 0; i < N; i++) begin
      if (act[i] && (!run_v || (prio[i] & pmask) < run_p)) begin
        run_v = 1'b1;
        run_p = prio[i] & pmask;
      end
    end
  end

  assign cand_take = cand_valid && (!run_v || ((cand_prio & pmask) < run_p));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 240,
  parameter int PRIO_BITS = 4,
  localparam int GW = $clog2(PRIO_BITS + 1),
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [11:0]          bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [3:0]           bus_be,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [GW-1:0]        prio_group,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic                 irq_valid,
  output logic                 irq_take,
  output logic [LW-1:0]        irq_line,
  output logic [PRIO_BITS-1:0] irq_prio,
  input  logic                 irq_ack,
  input  logic                 eos_valid,
  input  logic [LW-1:0]        eos_line
);

  localparam int N  = NUM_LINES;
  localparam int PB = PRIO_BITS;
  localparam int NW = (N + 31) / 32;

  bank_e        bank;
  logic [2:0]   widx;
  logic [31:0]  be_mask;
  logic [NW*32-1:0] wvec;
  logic [N-1:0] w_lines;
  logic [N-1:0] trig_v, ack_v, eos_v, prio_wr;
  logic [N-1:0] en_set, en_clr, pd_set, pd_clr;
  logic [N-1:0] en_q, pd_q, act_q;
  logic [N-1:0][PB-1:0] prio_q;
  logic         ack_ok;
  logic         cand_valid, cand_take;
  logic [LW-1:0] cand_line;
  logic [PB-1:0] cand_prio;
  logic [NW*32-1:0] en_pad, pd_pad, act_pad;
  logic [31:0]  rd_mux;

  assign bank   = bank_of(bus_addr);
  assign widx   = bus_addr[4:2];
  assign ack_ok = irq_ack && irq_take;

  always_comb begin
    for (int b = 0; b < 4; b++) be_mask[8*b +: 8] = {8{bus_be[b]}};
  end

  always_comb begin
    wvec = '0;
    for (int k = 0; k < NW; k++)
      if (widx == 3'(k)) wvec[k*32 +: 32] = bus_wdata & be_mask;
  end
  assign w_lines = wvec[N-1:0];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      trig_v[i]  = bus_wr && (bank == BK_TRIG) &&
                   (bus_wdata[TRIG_W-1:0] == TRIG_W'(i));
      ack_v[i]   = ack_ok && (irq_line == LW'(i));
      eos_v[i]   = eos_valid && (eos_line == LW'(i));
      prio_wr[i] = bus_wr && (bank == BK_PRIO) &&
                   (bus_addr[7:2] == 6'(i / 4)) && bus_be[i % 4];
    end
  end

  assign en_set = (bus_wr && bank == BK_EN_SET) ? w_lines : '0;
  assign en_clr = (bus_wr && bank == BK_EN_CLR) ? w_lines : '0;
  assign pd_set = ((bus_wr && bank == BK_PD_SET) ? w_lines : '0) | trig_v;
  assign pd_clr = ((bus_wr && bank == BK_PD_CLR) ? w_lines : '0) | ack_v;

  irqc_line_state #(.N(N)) u_state (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .en_set(en_set), .en_clr(en_clr),
    .pd_set(pd_set), .pd_clr(pd_clr),
    .act_set(ack_v), .act_clr(eos_v),
    .en_q(en_q), .pd_q(pd_q), .act_q(act_q)
  );

  irqc_prio_store #(.N(N), .PB(PB)) u_prio (
    .clk(clk), .rst(rst), .wr_mask(prio_wr), .wdata(bus_wdata), .prio_q(prio_q)
  );

  irqc_arbiter #(.N(N), .PB(PB), .GW(GW), .LW(LW)) u_arb (
    .en(en_q), .pd(pd_q), .act(act_q), .prio(prio_q), .group(prio_group),
    .cand_valid(cand_valid), .cand_line(cand_line),
    .cand_prio(cand_prio), .cand_take(cand_take)
  );

  // Read path
  always_comb begin
    en_pad  = '0; en_pad[N-1:0]  = en_q;
    pd_pad  = '0; pd_pad[N-1:0]  = pd_q;
    act_pad = '0; act_pad[N-1:0] = act_q;
  end

  function automatic logic [31:0] word_of(input logic [NW*32-1:0] v,
                                          input logic [2:0] w);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < NW; k++) if (w == 3'(k)) r = v[k*32 +: 32];
    return r;
  endfunction

  always_comb begin
    rd_mux = '0;
    case (bank)
      BK_EN_SET, BK_EN_CLR: rd_mux = word_of(en_pad, widx);
      BK_PD_SET, BK_PD_CLR: rd_mux = word_of(pd_pad, widx);
      BK_ACT:               rd_mux = word_of(act_pad, widx);
      BK_PRIO: begin
        for (int i = 0; i < N; i++)
          if (bus_addr[7:2] == 6'(i / 4)) rd_mux[8*(i%4)+7 -: PB] = prio_q[i];
      end
      default:              rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // Request outputs: registered; suppressed in the cycle after an ack so
  // the stale pick is never offered twice.
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= 1'b0;
      irq_take  <= 1'b0;
      irq_line  <= '0;
      irq_prio  <= '0;
    end else begin
      irq_valid <= cand_valid && !ack_ok;
      irq_take  <= cand_take  && !ack_ok;
      irq_line  <= cand_line;
      irq_prio  <= cand_prio;
    end
  end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N = 240,
  localparam int LW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          irq_valid,
  input logic          irq_take,
  input logic [LW-1:0] irq_line,
  input logic          irq_ack,
  input logic [N-1:0]  en_q,
  input logic [N-1:0]  pd_q,
  input logic [N-1:0]  act_q
);

  logic [N-1:0]  ready_d;
  logic          ack_d;
  logic [LW-1:0] ack_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_d <= '0;
      ack_d   <= 1'b0;
      ack_l   <= '0;
    end else begin
      ready_d <= en_q & pd_q;
      ack_d   <= irq_ack && irq_take;
      ack_l   <= irq_line;
    end
  end

  AST_PICK_ENABLED: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> ready_d[irq_line]); // R7
  AST_TAKE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> irq_valid); // R9
  AST_ACK_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_take) |=> (!irq_valid && !irq_take)); // R10
  AST_ACK_MAKES_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    ack_d |-> act_q[ack_l]); // R10
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_valid && !irq_take && act_q == '0)); // R12

endmodule

bind irqc_top irqc_checker #(.N(NUM_LINES)) u_chk (
  .clk(clk), .rst(rst), .irq_valid(irq_valid), .irq_take(irq_take),
  .irq_line(irq_line), .irq_ack(irq_ack),
  .en_q(en_q), .pd_q(pd_q), .act_q(act_q)
);

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
  localparam int N  = 40;
  localparam int PB = 4;
  localparam int GW = 3;
  localparam int LW = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic [11:0]   bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]    bus_be = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [GW-1:0] prio_group = '0;
  logic [N-1:0]  irq_in = '0;
  logic          irq_valid, irq_take;
  logic [LW-1:0] irq_line;
  logic [PB-1:0] irq_prio;
  logic          irq_ack = 1'b0;
  logic          eos_valid = 1'b0;
  logic [LW-1:0] eos_line = '0;

  irqc_top #(.NUM_LINES(N), .PRIO_BITS(PB)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .prio_group(prio_group), .irq_in(irq_in), .irq_valid(irq_valid),
    .irq_take(irq_take), .irq_line(irq_line), .irq_prio(irq_prio),
    .irq_ack(irq_ack), .eos_valid(eos_valid), .eos_line(eos_line)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_ack;
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
  endtask

  task automatic do_eos(input int line);
    @(negedge clk) begin eos_valid = 1'b1; eos_line = LW'(line); end
    @(negedge clk) eos_valid = 1'b0;
  endtask

  task automatic clear_all;
    wr(12'h080, 32'hFFFF_FFFF); wr(12'h084, 32'hFFFF_FFFF);
    wr(12'h180, 32'hFFFF_FFFF); wr(12'h184, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(12'h000, d); chk("R12 enable after reset", d, 0);
    rd(12'h300, d); chk("R12 priority after reset", d, 0);
    chk("R12 valid after reset", {31'b0, irq_valid}, 0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(12'h000, 32'h0000_0005);
    rd(12'h000, d); chk("R1 set alias readback", d, 32'h5);
    rd(12'h080, d); chk("R1 clear alias readback", d, 32'h5);
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, d); chk("R1 missing lines read 0", d, 32'h0000_00FF);
    rd(12'h008, d); chk("R1 missing word reads 0", d, 32'h0);
    wr(12'h080, 32'h0000_0001);
    rd(12'h000, d); chk("R1 clear one line", d, 32'h4);
    wr(12'h000, 32'h0000_0000);
    wr(12'h080, 32'h0000_0000);
    rd(12'h000, d); chk("R1 zero writes no effect", d, 32'h4);
    wr(12'h000, 32'h0000_0100, 4'b0001);
    rd(12'h000, d); chk("R1 disabled byte lane", d, 32'h4);
    clear_all();
  endtask

  task automatic t_pending;
    logic [31:0] d;
    wr(12'h100, 32'h0000_0030);
    rd(12'h180, d); chk("R2 pend set, clear alias read", d, 32'h30);
    wr(12'h180, 32'h0000_0010);
    rd(12'h100, d); chk("R2 pend clear", d, 32'h20);
    clear_all();
  endtask

  task automatic t_active_ro;
    logic [31:0] d;
    wr(12'h200, 32'hFFFF_FFFF);
    rd(12'h200, d); chk("R3 active not writable", d, 32'h0);
  endtask

  task automatic t_prio;
    logic [31:0] d;
    wr(12'h300, 32'hA5F3_1C7E, 4'b0101);
    rd(12'h300, d); chk("R4 priority lanes and low bits", d, 32'h00F0_0070);
  endtask

  task automatic t_trigger;
    logic [31:0] d;
    wr(12'hE00, 32'd35);
    rd(12'h104, d); chk("R5 trigger pends line 35", d, 32'h8);
    wr(12'hE00, 32'd45);
    rd(12'h104, d); chk("R5 out of range ignored", d, 32'h8);
    rd(12'hE00, d); chk("R5 trigger reads 0", d, 32'h0);
    clear_all();
  endtask

  task automatic t_hw_edge;
    logic [31:0] d;
    @(negedge clk) irq_in[7] = 1'b1;
    settle();
    rd(12'h100, d); chk("R6 edge pends disabled line", d, 32'h80);
    chk("R7 disabled line not shown", {31'b0, irq_valid}, 0);
    wr(12'h180, 32'h80);
    settle();
    rd(12'h100, d); chk("R6 held level no repend", d, 32'h0);
    @(negedge clk) irq_in[7] = 1'b0;
    settle();
  endtask

  task automatic t_arbiter;
    wr(12'h300, 32'h8000_0000, 4'b1000);
    wr(12'h304, 32'h0000_4000, 4'b0010);
    wr(12'h308, 32'h0000_4000, 4'b0010);
    wr(12'h324, 32'h0000_0020, 4'b0001);
    wr(12'h000, 32'h0000_0228);
    wr(12'h100, 32'h0000_0228);
    wr(12'h104, 32'h0000_0010);
    settle();
    chk("R7 valid", {31'b0, irq_valid}, 1);
    chk("R7 tie lowest line", {26'b0, irq_line}, 5);
    chk("R7 shown priority", {28'b0, irq_prio}, 4);
    wr(12'h004, 32'h0000_0010);
    settle();
    chk("R7 most urgent wins", {26'b0, irq_line}, 36);
    wr(12'h184, 32'h0000_0010);
    wr(12'h180, 32'h0000_0020);
    settle();
    chk("R7 next in order", {26'b0, irq_line}, 9);
    chk("R9 idle take", {31'b0, irq_take}, 1);
    clear_all();
  endtask

  task automatic t_preempt;
    logic [31:0] d;
    prio_group = 3'd2;
    wr(12'h300, 32'h0040_0000, 4'b0100);
    wr(12'h304, 32'h0000_0050, 4'b0001);
    wr(12'h304, 32'h0000_0000, 4'b0100);
    wr(12'h000, 32'h0000_0054);
    wr(12'h100, 32'h0000_0010);
    settle();
    chk("R9 take when idle", {irq_valid, irq_take, 24'b0, irq_line}, {2'b11, 30'd4});
    do_ack();
    chk("R10 valid drops after ack", {30'b0, irq_valid, irq_take}, 0);
    rd(12'h200, d); chk("R10 active set", d, 32'h10);
    rd(12'h100, d); chk("R10 pending cleared", d, 32'h0);
    wr(12'h100, 32'h0000_0004);
    settle();
    chk("R9 equal preemption no take", {irq_valid, irq_take, 24'b0, irq_line}, {2'b10, 30'd2});
    prio_group = 3'd4; settle();
    chk("R8 group 4 full compare", {31'b0, irq_take}, 1);
    prio_group = 3'd7; settle();
    chk("R8 group clamps", {31'b0, irq_take}, 1);
    prio_group = 3'd0; settle();
    chk("R8 group 0 no nesting", {31'b0, irq_take}, 0);
    prio_group = 3'd2; settle();
    wr(12'h100, 32'h0000_0040);
    settle();
    chk("R9 lower preemption takes", {irq_take, 25'b0, irq_line}, {1'b1, 31'd6});
    do_ack();
    rd(12'h200, d); chk("R10 nested active", d, 32'h50);
    settle();
    chk("R9 blocked by nested", {irq_valid, irq_take}, 2'b10);
    do_eos(6);
    settle();
    rd(12'h200, d); chk("R11 eos clears line 6", d, 32'h10);
    chk("R9 still blocked", {31'b0, irq_take}, 0);
    do_eos(4);
    settle();
    rd(12'h200, d); chk("R11 eos clears line 4", d, 32'h0);
    chk("R9 take after idle", {irq_take, 25'b0, irq_line}, {1'b1, 31'd2});
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_enable();
    t_pending();
    t_active_ro();
    t_prio();
    t_trigger();
    t_hw_edge();
    t_arbiter();
    t_preempt();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule